// File: doc/BRIEF.md
# Open-Page Tracker and Access Classifier

This block sits next to a DRAM command path. It keeps one entry per bank that says whether the bank is idle or has a row open, and if so which row. Each lookup names a bank and a row. The block sorts the lookup into one of three classes:

- **hit**: the row is already open.
- **empty**: the bank is idle.
- **miss**: a different row is open in that bank.

With the class it returns the expected access latency in clocks, built from the CAS latency, the activate-to-column delay and the precharge delay.

The command path reports every row activation and every precharge, single-bank or all-bank. The block updates its entries from these reports. A scheduler can then use the class and latency to rank pending requests. The block does not move data, enforce timing or schedule commands.

Top module: `page_tracker`

## Requirements
- R1: After reset every bank is idle and `class_valid_o` is low.
- R2: A lookup to an active bank whose stored row equals the requested row gives class hit (code 2'b00) with latency T_CL (6 by default).
- R3: A lookup to an idle bank gives class empty (code 2'b01) with latency T_RCD+T_CL (12 by default).
- R4: A lookup to an active bank holding a different row gives class miss (code 2'b10) with latency T_RP+T_RCD+T_CL (18 by default).
- R5: An activation report marks the named bank active and stores the reported row in full ROW_W-bit width.
- R6: A precharge report with `pre_all_i` low marks only bank `pre_bank_i` idle. All other banks keep their state.
- R7: A precharge report with `pre_all_i` high marks every bank idle.
- R8: A lookup is classified against the state before any activation or precharge report in the same cycle. Those reports affect lookups from the next cycle on.
- R9: If an activation and a precharge land on the same bank in one cycle, the activation wins and the bank ends active with the new row. This also applies when the precharge is the all-bank form.
- R10: Results appear one clock after the lookup, with `class_valid_o` high. In a cycle with no lookup the outputs read class 2'b11 and latency 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lookup_valid_i | input | 1 | Lookup request present |
| lookup_bank_i | input | BANK_W | Lookup bank |
| lookup_row_i | input | ROW_W | Lookup row |
| act_valid_i | input | 1 | Row activation report |
| act_bank_i | input | BANK_W | Activated bank |
| act_row_i | input | ROW_W | Activated row |
| pre_valid_i | input | 1 | Precharge report |
| pre_all_i | input | 1 | Precharge targets all banks |
| pre_bank_i | input | BANK_W | Precharged bank when not all |
| class_valid_o | output | 1 | Result valid |
| class_o | output | 2 | 00 hit, 01 empty, 10 miss, 11 none |
| latency_o | output | LAT_W | Expected access latency in clocks |

## Verification
Two things can happen to the same bank in one cycle: a lookup and a state update. An activation and a precharge can also both target the same bank in one cycle. Directed cases drive these pairs on one bank and check two things. The lookup result must reflect the old state. The following lookup must show the updated state, with the activation taking precedence. The random phase draws lookups, activations and precharges independently every cycle over a narrow row range, so these collisions also occur freely. A bench model scores every result.

// File: rtl/page_tracker_pkg.sv
package page_tracker_pkg;
  typedef enum logic [1:0] {
    CLS_HIT   = 2'b00,
    CLS_EMPTY = 2'b01,
    CLS_MISS  = 2'b10,
    CLS_NONE  = 2'b11
  } access_class_e;
endpackage

// File: rtl/bank_table.sv
module bank_table #(
  parameter int NUM_BANKS = 8,
  parameter int ROW_W     = 14,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              act_valid_i,
  input  logic [BANK_W-1:0]                 act_bank_i,
  input  logic [ROW_W-1:0]                  act_row_i,
  input  logic                              pre_valid_i,
  input  logic                              pre_all_i,
  input  logic [BANK_W-1:0]                 pre_bank_i,
  output logic [NUM_BANKS-1:0]              active_o,
  output logic [NUM_BANKS-1:0][ROW_W-1:0]   row_o
);
  logic [NUM_BANKS-1:0]            active_q;
  logic [NUM_BANKS-1:0][ROW_W-1:0] row_q;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic act_hit, pre_hit;
    assign act_hit = act_valid_i && (act_bank_i == BANK_W'(b));
    assign pre_hit = pre_valid_i && (pre_all_i || (pre_bank_i == BANK_W'(b)));

    // activation overrides a same-cycle precharge
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        active_q[b] <= 1'b0;
        row_q[b]    <= '0;
      end else if (act_hit) begin
        active_q[b] <= 1'b1;
        row_q[b]    <= act_row_i;
      end else if (pre_hit) begin
        active_q[b] <= 1'b0;
      end
    end
  end

  assign active_o = active_q;
  assign row_o    = row_q;

  a_r5_act_opens: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_valid_i |=> active_q[$past(act_bank_i)] && (row_q[$past(act_bank_i)] == $past(act_row_i)));

  a_r7_pre_all_idles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pre_valid_i && pre_all_i && !act_valid_i) |=> (active_q == '0));

  a_r6_pre_one_idles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pre_valid_i && !pre_all_i && !(act_valid_i && act_bank_i == pre_bank_i))
      |=> !active_q[$past(pre_bank_i)]);
endmodule

// File: rtl/page_classifier.sv
module page_classifier
  import page_tracker_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int ROW_W     = 14,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic [NUM_BANKS-1:0]            active_i,
  input  logic [NUM_BANKS-1:0][ROW_W-1:0] row_i,
  input  logic [BANK_W-1:0]               bank_i,
  input  logic [ROW_W-1:0]                req_row_i,
  output access_class_e                   class_o
);
  logic sel_active, row_match;
  assign sel_active = active_i[bank_i];
  assign row_match  = row_i[bank_i] == req_row_i;

  always_comb begin
    if (!sel_active)    class_o = CLS_EMPTY;
    else if (row_match) class_o = CLS_HIT;
    else                class_o = CLS_MISS;
  end
endmodule

// File: rtl/page_tracker.sv
module page_tracker
  import page_tracker_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int ROW_W     = 14,
  parameter int T_CL      = 6,
  parameter int T_RCD     = 6,
  parameter int T_RP      = 6,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int LAT_W    = $clog2(T_RP + T_RCD + T_CL + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lookup_valid_i,
  input  logic [BANK_W-1:0] lookup_bank_i,
  input  logic [ROW_W-1:0]  lookup_row_i,
  input  logic              act_valid_i,
  input  logic [BANK_W-1:0] act_bank_i,
  input  logic [ROW_W-1:0]  act_row_i,
  input  logic              pre_valid_i,
  input  logic              pre_all_i,
  input  logic [BANK_W-1:0] pre_bank_i,
  output logic              class_valid_o,
  output logic [1:0]        class_o,
  output logic [LAT_W-1:0]  latency_o
);
  localparam logic [LAT_W-1:0] LAT_HIT   = LAT_W'(T_CL);
  localparam logic [LAT_W-1:0] LAT_EMPTY = LAT_W'(T_RCD + T_CL);
  localparam logic [LAT_W-1:0] LAT_MISS  = LAT_W'(T_RP + T_RCD + T_CL);

  logic [NUM_BANKS-1:0]            active;
  logic [NUM_BANKS-1:0][ROW_W-1:0] rows;
  access_class_e                   cls_d;
  logic [LAT_W-1:0]                lat_d;

  logic              valid_q;
  access_class_e     cls_q;
  logic [LAT_W-1:0]  lat_q;

  bank_table #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W)) u_table (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .act_valid_i (act_valid_i),
    .act_bank_i  (act_bank_i),
    .act_row_i   (act_row_i),
    .pre_valid_i (pre_valid_i),
    .pre_all_i   (pre_all_i),
    .pre_bank_i  (pre_bank_i),
    .active_o    (active),
    .row_o       (rows)
  );

  page_classifier #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W)) u_cls (
    .active_i  (active),
    .row_i     (rows),
    .bank_i    (lookup_bank_i),
    .req_row_i (lookup_row_i),
    .class_o   (cls_d)
  );

  always_comb begin
    unique case (cls_d)
      CLS_HIT:   lat_d = LAT_HIT;
      CLS_EMPTY: lat_d = LAT_EMPTY;
      CLS_MISS:  lat_d = LAT_MISS;
      default:   lat_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      cls_q   <= CLS_NONE;
      lat_q   <= '0;
    end else if (lookup_valid_i) begin
      valid_q <= 1'b1;
      cls_q   <= cls_d;
      lat_q   <= lat_d;
    end else begin
      valid_q <= 1'b0;
      cls_q   <= CLS_NONE;
      lat_q   <= '0;
    end
  end

  assign class_valid_o = valid_q;
  assign class_o       = cls_q;
  assign latency_o     = lat_q;

  a_r10_follows_lookup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lookup_valid_i |=> class_valid_o && (class_o != CLS_NONE));

  a_r10_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !class_valid_o |-> (class_o == CLS_NONE) && (latency_o == '0));

  a_r3_idle_bank_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lookup_valid_i && !active[lookup_bank_i]) |=> (class_o == CLS_EMPTY) && (latency_o == LAT_EMPTY));

  a_r2_hit_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (class_valid_o && class_o == CLS_HIT) |-> latency_o == LAT_HIT);

  a_r4_miss_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (class_valid_o && class_o == CLS_MISS) |-> latency_o == LAT_MISS);
endmodule

// File: tb/page_tracker_tb_top.sv
module page_tracker_tb_top;
  localparam int NB = 8, BW = 3, RW = 14, LW = 5;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic lookup_valid_i = 0, act_valid_i = 0, pre_valid_i = 0, pre_all_i = 0;
  logic [BW-1:0] lookup_bank_i = '0, act_bank_i = '0, pre_bank_i = '0;
  logic [RW-1:0] lookup_row_i = '0, act_row_i = '0;
  logic class_valid_o;
  logic [1:0] class_o;
  logic [LW-1:0] latency_o;

  always #10 clk = ~clk;

  page_tracker dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .lookup_valid_i(lookup_valid_i), .lookup_bank_i(lookup_bank_i), .lookup_row_i(lookup_row_i),
    .act_valid_i(act_valid_i), .act_bank_i(act_bank_i), .act_row_i(act_row_i),
    .pre_valid_i(pre_valid_i), .pre_all_i(pre_all_i), .pre_bank_i(pre_bank_i),
    .class_valid_o(class_valid_o), .class_o(class_o), .latency_o(latency_o)
  );

  int errors = 0, checks = 0;
  bit done = 0;
  bit m_act [NB];
  logic [RW-1:0] m_row [NB];
  bit e_valid = 0;
  logic [1:0] e_cls = 2'b11;
  int e_lat = 0;
  string e_tag = "R10";

  function automatic int lat_of(logic [1:0] c);
    case (c)
      2'b00: return 6;
      2'b01: return 12;
      2'b10: return 18;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(logic [1:0] c);
    case (c)
      2'b00: return "R2";
      2'b01: return "R3";
      2'b10: return "R4";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got=%0d exp=%0d t=%0t", req, got, exp, $time);
    end
  endtask

  // model: classify on old state, then apply pre, then act (act wins)
  task automatic drive(bit lv, int lb, int lr, bit av, int ab, int ar,
                       bit pv, bit pa, int pb, string tag);
    @(negedge clk);
    chk({e_tag, " valid"}, class_valid_o, e_valid);
    chk({e_tag, " class"}, class_o, e_cls);
    chk({e_tag, " latency"}, latency_o, e_lat);
    lookup_valid_i = lv; lookup_bank_i = BW'(lb); lookup_row_i = RW'(lr);
    act_valid_i = av; act_bank_i = BW'(ab); act_row_i = RW'(ar);
    pre_valid_i = pv; pre_all_i = pa; pre_bank_i = BW'(pb);
    e_valid = lv;
    if (!lv) e_cls = 2'b11;
    else if (!m_act[lb]) e_cls = 2'b01;
    else if (m_row[lb] == RW'(lr)) e_cls = 2'b00;
    else e_cls = 2'b10;
    e_lat = lat_of(e_cls);
    e_tag = (tag != "") ? tag : tag_of(e_cls);
    if (pv) for (int b = 0; b < NB; b++) if (pa || b == pb) m_act[b] = 0;
    if (av) begin m_act[ab] = 1; m_row[ab] = RW'(ar); end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int b = 0; b < NB; b++) begin m_act[b] = 0; m_row[b] = '0; end
    repeat (2) @(negedge clk);
    chk("R1 reset valid", class_valid_o, 0);
    chk("R1 reset class", class_o, 3);
    rst_ni = 1'b1;
    // R1: every bank idle after reset
    for (int b = 0; b < NB; b++) drive(1, b, 7, 0, 0, 0, 0, 0, 0, "R1");
    // R8: act in lookup cycle not seen; R5 row stored full width
    drive(1, 3, 14'h3abc, 1, 3, 14'h3abc, 0, 0, 0, "R8");
    drive(1, 3, 14'h3abc, 0, 0, 0, 0, 0, 0, "R5");
    drive(1, 3, 14'h1abc, 0, 0, 0, 0, 0, 0, "R4");
    drive(1, 5, 1, 1, 5, 1, 0, 0, 0, "R3");
    // R6: single precharge of bank 3 leaves bank 5 open
    drive(1, 3, 14'h3abc, 0, 0, 0, 1, 0, 3, "R8");
    drive(1, 3, 14'h3abc, 0, 0, 0, 0, 0, 0, "R6");
    drive(1, 5, 1, 0, 0, 0, 0, 0, 0, "R6");
    // R9: act and pre same bank, act wins
    drive(0, 0, 0, 1, 2, 9, 1, 0, 2, "R10");
    drive(1, 2, 9, 1, 6, 4, 1, 1, 0, "R9");
    drive(1, 6, 4, 0, 0, 0, 0, 0, 0, "R9");
    drive(1, 5, 1, 0, 0, 0, 0, 0, 0, "R7");
    drive(1, 2, 9, 0, 0, 0, 1, 1, 0, "R7");
    drive(1, 6, 4, 0, 0, 0, 0, 0, 0, "R7");
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, "R10");
    // random mix over a narrow row range
    for (int i = 0; i < 3000; i++) begin
      int r0 = $urandom;
      drive(r0[0] | r0[1], $urandom_range(NB-1), $urandom_range(3),
            (r0[4:2] == 0), $urandom_range(NB-1), $urandom_range(3),
            (r0[7:5] == 0), (r0[9:8] == 0), $urandom_range(NB-1), "");
    end
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, "");
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, "R10");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule